// File: doc/BRIEF.md
# Receive Buffer Packet Skip Controller

This block controls the read side of a circular receive buffer. Packets sit in the buffer one after another. Each packet starts with a 16-bit length header, stored low byte first, and is padded to an even number of bytes. The host pulls bytes one at a time with a read strobe. Each strobe returns the byte at the read pointer and moves the pointer forward. When the last padded byte of a packet has been read, the controller moves on to the next packet by itself.

A one-bit control register lets the host drop the unread tail of the current packet. A write with bit 2 set starts a skip. The controller works out where the next packet starts from the header and jumps there. While this happens, bit 2 reads back as 1. The skip is refused, and flagged, when it could corrupt the pointers: too few bytes have been read since the packet start, too few bytes are left, no packet is stored, or a skip is already running.

The buffer memory is a simple internal RAM. A load port fills it, and a commit pulse announces each complete packet that has been stored.

Top module: `rxbuf_skip_ctrl`

## Requirements
- R1: `reg_rdata` shows the busy state in bit 2, and every other bit reads 0 at all times.
- R2: An accepted skip request makes bit 2 read 1 in the cycle after the write, and 0 again in the cycle after that, well inside a 6-cycle limit.
- R3: After a skip, the read pointer equals the packet start plus 2 plus the length, rounded up to even and taken modulo the buffer size. The next strobe returns the low header byte of the following packet.
- R4: A skip request made after fewer than 4 bytes have been read since the packet start raises `skip_err` for one cycle and changes nothing else.
- R5: A skip request made when 8 or fewer padded bytes of the packet remain raises `skip_err` and is ignored.
- R6: A skip request made while no packet is stored, or while a skip is already running, raises `skip_err` and is ignored.
- R7: A read strobe puts the byte at the read pointer on `rd_data` one cycle later and advances the pointer by one. Byte 0 of a packet is the low byte of its length, and byte 1 is the high byte.
- R8: A read strobe issued while a skip is running, or while no packet is stored, sets `rd_data` to 0 and does not move the pointer.
- R9: `pkt_avail` is 1 exactly when the stored-packet count is nonzero. A commit adds one to the count, a finished skip or a finished read-out removes one, and both in the same cycle leave the count unchanged.
- R10: Reading the final padded byte of a packet moves the controller to the next packet. If no other packet is stored, `pkt_avail` falls to 0.
- R11: A register write with bit 2 clear has no effect on the busy bit, the error flag or the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data; bit 2 requests a skip |
| reg_rdata | output | 8 | Control register read value; bit 2 is busy |
| skip_err | output | 1 | One-cycle pulse when a skip request is refused |
| rd_strobe | input | 1 | Host byte read request |
| rd_data | output | 8 | Byte returned one cycle after a strobe |
| pkt_avail | output | 1 | At least one complete packet is stored |
| ld_we | input | 1 | Buffer load write enable |
| ld_addr | input | ADDR_W | Buffer load address |
| ld_data | input | 8 | Buffer load byte |
| pkt_commit | input | 1 | Pulse: one more complete packet is in the buffer |

## Verification
The assertions assume that the loading side is well behaved. It never commits a packet when the count is already at its maximum. It writes every byte of a packet, header and padding included, before it pulses commit. It never writes over bytes of a packet that is still stored. The stimulus keeps to these rules by tracking its own write pointer: it loads new packets only into space that has already been read or skipped, and it keeps the number of stored packets small. Packet lengths are kept below the buffer size, so the header always describes a packet that fits in the buffer.

// File: rtl/rxskip_pkg.sv
package rxskip_pkg;
  localparam int LEN_W = 16;
  typedef logic [LEN_W:0] span_t;

  // header plus payload, rounded up to an even byte count
  function automatic span_t padded_total(input logic [LEN_W-1:0] len);
    span_t s;
    s = span_t'(len) + span_t'(3);
    s[0] = 1'b0;
    return s;
  endfunction

  function automatic logic skip_window_ok(input span_t done, input span_t total,
                                          input int unsigned min_reads,
                                          input int unsigned min_left);
    return (done >= span_t'(min_reads)) && ((total - done) > span_t'(min_left));
  endfunction
endpackage

// File: rtl/rxskip_ram.sv
module rxskip_ram #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_q,
  input  logic [ADDR_W-1:0] hdr_addr,
  output logic [15:0]       hdr_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [ADDR_W-1:0] hdr_addr_hi;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign hdr_addr_hi = hdr_addr + 1'b1;
  assign byte_q = mem[byte_addr];
  assign hdr_q  = {mem[hdr_addr_hi], mem[hdr_addr]};
endmodule

// File: rtl/rxskip_regif.sv
module rxskip_regif #(
  parameter int SKIP_BIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  input  logic       window_ok,
  output logic       skip_go,
  output logic       busy,
  output logic       skip_err,
  output logic [7:0] reg_rdata
);
  logic skip_req;

  assign skip_req  = reg_we & reg_wdata[SKIP_BIT];
  assign skip_go   = skip_req & window_ok & ~busy;
  assign reg_rdata = 8'(busy) << SKIP_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      skip_err <= 1'b0;
    end else begin
      busy     <= skip_go;
      skip_err <= skip_req & ~skip_go;
    end
  end

  // R2: the busy bit never lasts longer than one cycle
  assert_busy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/rxskip_ptr.sv
module rxskip_ptr
  import rxskip_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 4,
  parameter int MIN_READS = 4,
  parameter int MIN_LEFT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic              busy,
  input  logic              commit,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic [7:0]        mem_byte,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] pkt_start,
  output logic [7:0]        rd_data,
  output logic              pkt_avail,
  output logic              window_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  span_t             done;
  span_t             total;
  logic [CNT_W-1:0]  cnt;
  logic              rd_fire;
  logic              last_byte;
  logic              pkt_dec;
  logic [ADDR_W-1:0] next_start;
  logic [ADDR_W-1:0] ptr_inc;

  assign total      = padded_total(hdr_len);
  assign pkt_avail  = (cnt != '0);
  assign window_ok  = pkt_avail && skip_window_ok(done, total, MIN_READS, MIN_LEFT);
  assign rd_fire    = rd_strobe & pkt_avail & ~busy;
  assign last_byte  = rd_fire && (span_t'(done + 1'b1) == total);
  assign pkt_dec    = busy | last_byte;
  assign next_start = pkt_start + ADDR_W'(total);
  assign ptr_inc    = rd_ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      pkt_start <= '0;
      done      <= '0;
      cnt       <= '0;
      rd_data   <= '0;
    end else begin
      if (rd_strobe) rd_data <= rd_fire ? mem_byte : 8'h00;
      if (busy) begin
        rd_ptr    <= next_start;
        pkt_start <= next_start;
        done      <= '0;
      end else if (rd_fire) begin
        rd_ptr <= ptr_inc;
        if (last_byte) begin
          pkt_start <= ptr_inc;
          done      <= '0;
        end else begin
          done <= done + 1'b1;
        end
      end
      case ({commit, pkt_dec})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // R10: the read position stays inside the current packet
  assert_done_in_pkt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_avail |-> (done < total));
  // R9: a skip only runs while a packet is stored
  assert_skip_has_pkt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pkt_avail);
  // R9: input rule, the count is never pushed past its maximum
  assert_cnt_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !pkt_dec) |-> (cnt != CNT_MAX));
  // R3: a finished skip leaves the pointer on a fresh packet start
  assert_skip_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done == '0 && rd_ptr == pkt_start));
  // R8: a strobe during a skip returns zero
  assert_busy_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy) |=> (rd_data == 8'h00));
endmodule

// File: rtl/rxbuf_skip_ctrl.sv
module rxbuf_skip_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 4,
  parameter int MIN_READS = 4,
  parameter int MIN_LEFT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              skip_err,
  input  logic              rd_strobe,
  output logic [7:0]        rd_data,
  output logic              pkt_avail,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              pkt_commit
);
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] pkt_start;
  logic [7:0]        mem_byte;
  logic [15:0]       hdr_len;
  logic              window_ok;
  logic              skip_go;
  logic              busy;

  rxskip_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
    .byte_addr(rd_ptr), .byte_q(mem_byte),
    .hdr_addr(pkt_start), .hdr_q(hdr_len)
  );

  rxskip_regif #(.SKIP_BIT(2)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .window_ok(window_ok), .skip_go(skip_go), .busy(busy),
    .skip_err(skip_err), .reg_rdata(reg_rdata)
  );

  rxskip_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MIN_READS(MIN_READS),
               .MIN_LEFT(MIN_LEFT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .busy(busy),
    .commit(pkt_commit), .hdr_len(hdr_len), .mem_byte(mem_byte),
    .rd_ptr(rd_ptr), .pkt_start(pkt_start), .rd_data(rd_data),
    .pkt_avail(pkt_avail), .window_ok(window_ok)
  );

  // R6: the register only accepts a skip when the window is legal
  assert_go_needs_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_go |-> (window_ok && pkt_avail));
endmodule

// File: tb/rxbuf_skip_ctrl_tb.sv
module rxbuf_skip_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       skip_err;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       pkt_avail;
  logic       ld_we = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic       pkt_commit = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;
  int wp = 0;

  // reference model state
  int m_mem [256];
  int m_rp, m_start, m_done, m_cnt, m_data, m_len, m_tot, m_dec;
  bit m_busy, m_err, m_avail, m_req, m_legal, m_fire;

  always #5 clk = ~clk;

  rxbuf_skip_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .skip_err(skip_err), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .pkt_avail(pkt_avail), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .pkt_commit(pkt_commit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rp = 0; m_start = 0; m_done = 0; m_cnt = 0;
      m_busy = 0; m_err = 0; m_data = 0;
    end else begin
      m_len = m_mem[m_start] + 256 * m_mem[(m_start + 1) % 256];
      m_tot = ((m_len + 3) / 2) * 2;
      m_avail = (m_cnt > 0);
      m_req = reg_we && reg_wdata[2];
      m_legal = m_avail && !m_busy && (m_done >= 4) && ((m_tot - m_done) > 8);
      m_fire = rd_strobe && m_avail && !m_busy;
      if (rd_strobe) m_data = m_fire ? m_mem[m_rp] : 0;
      m_dec = 0;
      if (m_busy) begin
        m_rp = (m_start + m_tot) % 256;
        m_start = m_rp;
        m_done = 0;
        m_dec = 1;
      end else if (m_fire) begin
        m_rp = (m_rp + 1) % 256;
        m_done++;
        if (m_done == m_tot) begin
          m_start = m_rp;
          m_done = 0;
          m_dec = 1;
        end
      end
      m_cnt = m_cnt + int'(pkt_commit) - m_dec;
      m_busy = m_req && m_legal;
      m_err = m_req && !m_legal;
      if (ld_we) m_mem[ld_addr] = ld_data;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 reg_rdata", reg_rdata, m_busy ? 4 : 0);
      chk("R4 skip_err", skip_err, m_err);
      chk("R7 rd_data", rd_data, m_data);
      chk("R9 pkt_avail", pkt_avail, m_cnt > 0);
    end
  end

  task automatic rd1();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic rdn(input int n);
    for (int i = 0; i < n; i++) rd1();
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic put(input int v);
    ld_we = 1'b1;
    ld_addr = 8'(wp);
    ld_data = 8'(v);
    @(negedge clk);
    ld_we = 1'b0;
    wp = (wp + 1) % 256;
  endtask

  task automatic load_pkt(input int len, input int base);
    put(len % 256);
    put(len / 256);
    for (int i = 0; i < len; i++) put(base + i);
    if (len % 2 == 1) put(0);
  endtask

  task automatic commit1();
    pkt_commit = 1'b1;
    @(negedge clk);
    pkt_commit = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    chk("R1 reset reg", reg_rdata, 0);
    chk("R9 reset avail", pkt_avail, 0);

    load_pkt(20, 8'h10);
    commit1();
    load_pkt(13, 8'h40);
    commit1();
    chk("R9 two stored", pkt_avail, 1);

    rdn(2);
    wr(8'h04);
    chk("R4 early skip refused", skip_err, 1);
    chk("R4 no busy", reg_rdata, 0);
    rdn(2);
    chk("R4 reads continue", rd_data, 8'h11);

    wr(8'h04);
    chk("R2 busy visible", reg_rdata, 8'h04);
    rd1();
    chk("R8 read during skip", rd_data, 0);
    chk("R2 busy cleared", reg_rdata, 0);
    rd1();
    chk("R3 next header low", rd_data, 13);

    wr(8'hFB);
    chk("R11 no busy", reg_rdata, 0);
    chk("R11 no error", skip_err, 0);
    rd1();
    chk("R11 pointer kept", rd_data, 0);

    rdn(6);
    wr(8'h04);
    chk("R5 tail skip refused", skip_err, 1);
    rd1();
    chk("R5 pointer kept", rd_data, 8'h46);
    rdn(7);
    chk("R10 pad byte", rd_data, 0);
    chk("R10 buffer empty", pkt_avail, 0);

    rd1();
    chk("R8 read with no packet", rd_data, 0);
    wr(8'h04);
    chk("R6 skip with no packet", skip_err, 1);

    load_pkt(100, 8'h80);
    commit1();
    load_pkt(150, 8'h20);
    commit1();
    rdn(4);
    wr(8'h04);
    @(negedge clk);
    rd1();
    chk("R3 wrap target header", rd_data, 150);
    rdn(5);
    load_pkt(9, 8'hC0);
    wr(8'h04);
    wr(8'h04);
    chk("R6 skip while busy", skip_err, 1);
    pkt_commit = 1'b1;
    @(negedge clk);
    pkt_commit = 1'b0;
    chk("R9 commit with skip", pkt_avail, 1);
    rd1();
    chk("R3 wrapped start", rd_data, 9);
    rdn(11);
    chk("R10 last byte", rd_data, 0);
    chk("R10 drained", pkt_avail, 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule